// File: doc/BRIEF.md
# Erase High-Voltage Start Interlock

This block decides when a flash erase may receive its high-voltage start. It keeps a control register with per-block protect bits, per-block select bits, a program-enable bit, a select-erase bit and a high-voltage request bit. It also watches write strobes aimed at the array address window. The start is granted only after three things happen in order: a control write arms the sequencer with program-enable and select-erase both set, then a dummy write lands inside the array window, then a control write requests high voltage. When the start is granted, the block samples the two external protection-enable inputs and produces the set of blocks to erase. It sends a one-cycle start pulse with that state to a downstream erase scheduler. The block stays busy until the scheduler reports completion.

A block joins the erase only if its select bit is set and its protect bit is clear. A small block must also be enabled by its configuration input. A high-voltage request that arrives out of order never produces a start. Instead it sets a sticky error flag. While an erase runs, the control register is frozen. Because the protection state is captured at the start, later changes on the protection inputs cannot change an erase that is already running.

Top module: `erase_hv_gate`

## Requirements
- R1: After reset, busy, hv_start, seq_err, rd_hv, rd_pe, rd_ses, the select readbacks, both erase masks and both latched protection outputs read 0. Both protect readbacks read all ones.
- R2: A control write while not busy loads every protect, select, program-enable and select-erase field. The new values show on the readback ports in the next cycle.
- R3: An array write arms the interlock only when the sequencer is already armed (program-enable and select-erase both 1) and the address lies within [ARR_BASE, ARR_BASE+ARR_SIZE-1]. Addresses outside that window, and array writes made while idle, are ignored.
- R4: A control write with the high-voltage bit set, made after the interlock write, produces exactly one hv_start cycle in the following cycle. In that same cycle busy and rd_hv become 1.
- R5: A high-voltage request made before the interlock write produces no hv_start and leaves rd_hv at 0. It sets seq_err to 1, and seq_err stays set until a later start is granted, which clears it.
- R6: A control write with program-enable or select-erase at 0 returns the sequencer to idle. A high-voltage request that follows is then rejected as in R5 until a new interlock write has been made.
- R7: prot_en_lat and blk0_prot_en_lat take the values of prot_en_in and blk0_prot_en_in at the granting write. They stay unchanged until the next start, whatever the inputs do.
- R8: At a start, erase_blk[i] = select[i] AND NOT protect[i], and erase_sb[j] = small select[j] AND NOT small protect[j] AND sb_en[j]. The fields are the ones carried by the granting write.
- R9: While busy, control writes are ignored: every readback holds its value and no second start is issued.
- R10: erase_done while busy clears busy and rd_hv in the next cycle. erase_done while not busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| wr_prot | input | NUM_BLK | Write data: main block protect bits |
| wr_sbprot | input | NUM_SB | Write data: small block protect bits |
| wr_sel | input | NUM_BLK | Write data: main block select bits |
| wr_sbsel | input | NUM_SB | Write data: small block select bits |
| wr_pe | input | 1 | Write data: program-enable |
| wr_ses | input | 1 | Write data: select-erase |
| wr_hv | input | 1 | Write data: high-voltage request |
| arr_wr | input | 1 | Array write strobe |
| arr_addr | input | ADDR_W | Array write address |
| sb_en | input | NUM_SB | Small block enables (configuration) |
| prot_en_in | input | 1 | Array-wide protection enable, sampled at start |
| blk0_prot_en_in | input | 1 | Block 0 protection enable, sampled at start |
| erase_done | input | 1 | Erase completion from the scheduler |
| rd_prot | output | NUM_BLK | Readback: main protect bits |
| rd_sbprot | output | NUM_SB | Readback: small protect bits |
| rd_sel | output | NUM_BLK | Readback: main select bits |
| rd_sbsel | output | NUM_SB | Readback: small select bits |
| rd_pe | output | 1 | Readback: program-enable |
| rd_ses | output | 1 | Readback: select-erase |
| rd_hv | output | 1 | Readback: high voltage active |
| busy | output | 1 | Erase in progress |
| seq_err | output | 1 | Sticky out-of-order request flag |
| hv_start | output | 1 | One-cycle start pulse to the scheduler |
| erase_blk | output | NUM_BLK | Main blocks to erase |
| erase_sb | output | NUM_SB | Small blocks to erase |
| prot_en_lat | output | 1 | Latched array protection enable |
| blk0_prot_en_lat | output | 1 | Latched block 0 protection enable |

## Verification
The bench builds the block with NUM_BLK=6, NUM_SB=2, ADDR_W=12 and an array window from 0x200 to 0x37F. The window size of 0x180 is not a power of two, so this build uses the full range-compare variant of the window decoder. Both edges of the window, and the addresses just outside them, are reached with directed writes. Six main blocks and two small blocks are few enough that random select, protect and enable patterns cover empty masks, full masks and masks where protection removes every selected block. A 12-bit address keeps random array writes landing inside the window often, so the sequence of arm, interlock and request is completed many times under random stimulus.

// File: rtl/ehg_pkg.sv
package ehg_pkg;

   typedef enum logic [1:0] {
      EHG_IDLE   = 2'd0,
      EHG_ARMED  = 2'd1,
      EHG_LOCKED = 2'd2,
      EHG_BUSY   = 2'd3
   } ehg_state_e;

endpackage

// File: rtl/ehg_win_dec.sv
module ehg_win_dec #(
   parameter int          ADDR_W   = 16,
   parameter int unsigned ARR_BASE = 32'h0000_8000,
   parameter int unsigned ARR_SIZE = 32'h0000_8000
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);

   localparam bit IS_POW2 = ((ARR_SIZE & (ARR_SIZE - 1)) == 0) &&
                            ((ARR_BASE % ARR_SIZE) == 0);
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(ARR_BASE);
   localparam logic [ADDR_W-1:0] LAST_V = ADDR_W'(ARR_BASE + ARR_SIZE - 1);
   localparam logic [ADDR_W-1:0] MASK_V = ~ADDR_W'(ARR_SIZE - 1);

   generate
      if (IS_POW2) begin : g_aligned
         // aligned power-of-two window: one masked equality
         assign hit = ((addr & MASK_V) == BASE_V);
      end else begin : g_range
         // arbitrary window: two magnitude comparators
         assign hit = (addr >= BASE_V) && (addr <= LAST_V);
      end
   endgenerate

endmodule

// File: rtl/ehg_ctl_reg.sv
module ehg_ctl_reg #(
   parameter int NUM_BLK = 8,
   parameter int NUM_SB  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [NUM_BLK-1:0] wr_prot,
   input  logic [NUM_SB-1:0]  wr_sbprot,
   input  logic [NUM_BLK-1:0] wr_sel,
   input  logic [NUM_SB-1:0]  wr_sbsel,
   input  logic               wr_pe,
   input  logic               wr_ses,
   input  logic               hv_set,
   input  logic               hv_clr,
   output logic [NUM_BLK-1:0] prot_q,
   output logic [NUM_SB-1:0]  sbprot_q,
   output logic [NUM_BLK-1:0] sel_q,
   output logic [NUM_SB-1:0]  sbsel_q,
   output logic               pe_q,
   output logic               ses_q,
   output logic               hv_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot_q   <= '1;
         sbprot_q <= '1;
         sel_q    <= '0;
         sbsel_q  <= '0;
         pe_q     <= 1'b0;
         ses_q    <= 1'b0;
      end else if (wr_en) begin
         prot_q   <= wr_prot;
         sbprot_q <= wr_sbprot;
         sel_q    <= wr_sel;
         sbsel_q  <= wr_sbsel;
         pe_q     <= wr_pe;
         ses_q    <= wr_ses;
      end
   end

   // high-voltage bit is never stored from write data; only a grant sets it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hv_q <= 1'b0;
      else if (hv_set) hv_q <= 1'b1;
      else if (hv_clr) hv_q <= 1'b0;
   end

endmodule

// File: rtl/ehg_seq_fsm.sv
module ehg_seq_fsm
   import ehg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_wr,
   input  logic       wr_pe,
   input  logic       wr_ses,
   input  logic       wr_hv,
   input  logic       arr_hit,
   input  logic       erase_done,
   output ehg_state_e state_q,
   output logic       grant,
   output logic       start_q,
   output logic       err_q
);

   ehg_state_e state_d;
   logic       err_d;

   always_comb begin
      state_d = state_q;
      err_d   = err_q;
      grant   = 1'b0;
      if (state_q == EHG_BUSY) begin
         if (erase_done) state_d = EHG_IDLE;
      end else if (ctl_wr) begin
         if (!(wr_pe && wr_ses)) begin
            state_d = EHG_IDLE;
            if (wr_hv) err_d = 1'b1;
         end else if (wr_hv && (state_q == EHG_LOCKED)) begin
            grant   = 1'b1;
            state_d = EHG_BUSY;
            err_d   = 1'b0;
         end else begin
            if (wr_hv) err_d = 1'b1;
            state_d = (state_q == EHG_LOCKED) ? EHG_LOCKED : EHG_ARMED;
         end
      end else if (arr_hit && (state_q == EHG_ARMED)) begin
         state_d = EHG_LOCKED;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= EHG_IDLE;
         err_q   <= 1'b0;
         start_q <= 1'b0;
      end else begin
         state_q <= state_d;
         err_q   <= err_d;
         start_q <= grant;
      end
   end

endmodule

// File: rtl/ehg_launch.sv
module ehg_launch #(
   parameter int NUM_BLK = 8,
   parameter int NUM_SB  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               grant,
   input  logic [NUM_BLK-1:0] wr_prot,
   input  logic [NUM_SB-1:0]  wr_sbprot,
   input  logic [NUM_BLK-1:0] wr_sel,
   input  logic [NUM_SB-1:0]  wr_sbsel,
   input  logic [NUM_SB-1:0]  sb_en,
   input  logic               prot_en_in,
   input  logic               blk0_prot_en_in,
   output logic [NUM_BLK-1:0] blk_q,
   output logic [NUM_SB-1:0]  sb_q,
   output logic               prot_en_q,
   output logic               blk0_prot_en_q
);

   logic [NUM_BLK-1:0] blk_d;
   logic [NUM_SB-1:0]  sb_d;

   generate
      for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
         assign blk_d[i] = wr_sel[i] & ~wr_prot[i];
      end
      for (genvar j = 0; j < NUM_SB; j++) begin : g_sb
         assign sb_d[j] = wr_sbsel[j] & ~wr_sbprot[j] & sb_en[j];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_q          <= '0;
         sb_q           <= '0;
         prot_en_q      <= 1'b0;
         blk0_prot_en_q <= 1'b0;
      end else if (grant) begin
         blk_q          <= blk_d;
         sb_q           <= sb_d;
         prot_en_q      <= prot_en_in;
         blk0_prot_en_q <= blk0_prot_en_in;
      end
   end

endmodule

// File: rtl/erase_hv_gate.sv
module erase_hv_gate
   import ehg_pkg::*;
#(
   parameter int          NUM_BLK  = 8,
   parameter int          NUM_SB   = 2,
   parameter int          ADDR_W   = 16,
   parameter int unsigned ARR_BASE = 32'h0000_8000,
   parameter int unsigned ARR_SIZE = 32'h0000_8000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctl_wr,
   input  logic [NUM_BLK-1:0] wr_prot,
   input  logic [NUM_SB-1:0]  wr_sbprot,
   input  logic [NUM_BLK-1:0] wr_sel,
   input  logic [NUM_SB-1:0]  wr_sbsel,
   input  logic               wr_pe,
   input  logic               wr_ses,
   input  logic               wr_hv,
   input  logic               arr_wr,
   input  logic [ADDR_W-1:0]  arr_addr,
   input  logic [NUM_SB-1:0]  sb_en,
   input  logic               prot_en_in,
   input  logic               blk0_prot_en_in,
   input  logic               erase_done,
   output logic [NUM_BLK-1:0] rd_prot,
   output logic [NUM_SB-1:0]  rd_sbprot,
   output logic [NUM_BLK-1:0] rd_sel,
   output logic [NUM_SB-1:0]  rd_sbsel,
   output logic               rd_pe,
   output logic               rd_ses,
   output logic               rd_hv,
   output logic               busy,
   output logic               seq_err,
   output logic               hv_start,
   output logic [NUM_BLK-1:0] erase_blk,
   output logic [NUM_SB-1:0]  erase_sb,
   output logic               prot_en_lat,
   output logic               blk0_prot_en_lat
);

   generate
      if (NUM_BLK < 1 || NUM_BLK > 64) begin : g_bad_blk
         $error("erase_hv_gate: NUM_BLK out of range");
      end
      if (NUM_SB < 1 || NUM_SB > 16) begin : g_bad_sb
         $error("erase_hv_gate: NUM_SB out of range");
      end
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_aw
         $error("erase_hv_gate: ADDR_W out of range");
      end
      if (ARR_SIZE == 0 ||
          (longint'(ARR_BASE) + longint'(ARR_SIZE)) > (longint'(1) << ADDR_W)) begin : g_bad_win
         $error("erase_hv_gate: array window does not fit the address space");
      end
   endgenerate

   ehg_state_e state;
   logic       win_hit;
   logic       grant;

   ehg_win_dec #(
      .ADDR_W  (ADDR_W),
      .ARR_BASE(ARR_BASE),
      .ARR_SIZE(ARR_SIZE)
   ) u_win (
      .addr(arr_addr),
      .hit (win_hit)
   );

   ehg_seq_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr),
      .wr_pe     (wr_pe),
      .wr_ses    (wr_ses),
      .wr_hv     (wr_hv),
      .arr_hit   (arr_wr & win_hit),
      .erase_done(erase_done),
      .state_q   (state),
      .grant     (grant),
      .start_q   (hv_start),
      .err_q     (seq_err)
   );

   assign busy = (state == EHG_BUSY);

   ehg_ctl_reg #(
      .NUM_BLK(NUM_BLK),
      .NUM_SB (NUM_SB)
   ) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ctl_wr & ~busy),
      .wr_prot  (wr_prot),
      .wr_sbprot(wr_sbprot),
      .wr_sel   (wr_sel),
      .wr_sbsel (wr_sbsel),
      .wr_pe    (wr_pe),
      .wr_ses   (wr_ses),
      .hv_set   (grant),
      .hv_clr   (busy & erase_done),
      .prot_q   (rd_prot),
      .sbprot_q (rd_sbprot),
      .sel_q    (rd_sel),
      .sbsel_q  (rd_sbsel),
      .pe_q     (rd_pe),
      .ses_q    (rd_ses),
      .hv_q     (rd_hv)
   );

   ehg_launch #(
      .NUM_BLK(NUM_BLK),
      .NUM_SB (NUM_SB)
   ) u_launch (
      .clk            (clk),
      .rst_n          (rst_n),
      .grant          (grant),
      .wr_prot        (wr_prot),
      .wr_sbprot      (wr_sbprot),
      .wr_sel         (wr_sel),
      .wr_sbsel       (wr_sbsel),
      .sb_en          (sb_en),
      .prot_en_in     (prot_en_in),
      .blk0_prot_en_in(blk0_prot_en_in),
      .blk_q          (erase_blk),
      .sb_q           (erase_sb),
      .prot_en_q      (prot_en_lat),
      .blk0_prot_en_q (blk0_prot_en_lat)
   );

endmodule

// File: rtl/ehg_chk.sv
module ehg_chk #(
   parameter int NUM_BLK = 8,
   parameter int NUM_SB  = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ctl_wr,
   input logic               wr_hv,
   input logic               erase_done,
   input logic               busy,
   input logic               hv_start,
   input logic               seq_err,
   input logic               rd_hv,
   input logic [NUM_BLK-1:0] rd_prot,
   input logic [NUM_BLK-1:0] rd_sel,
   input logic [NUM_SB-1:0]  rd_sbprot,
   input logic [NUM_SB-1:0]  rd_sbsel,
   input logic [NUM_BLK-1:0] erase_blk,
   input logic [NUM_SB-1:0]  erase_sb,
   input logic               prot_en_lat,
   input logic               blk0_prot_en_lat
);

   p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hv_start |=> !hv_start);

   p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hv_start |-> (busy && rd_hv));

   p_req_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wr_hv && !busy) |=> (hv_start || seq_err));

   p_lat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !hv_start) |-> ($stable(prot_en_lat) && $stable(blk0_prot_en_lat)));

   p_mask_unprot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hv_start |-> (((erase_blk & rd_prot) == '0) && ((erase_sb & rd_sbprot) == '0) &&
                    ((erase_blk & ~rd_sel) == '0) && ((erase_sb & ~rd_sbsel) == '0)));

   p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !hv_start) |-> ($stable(rd_prot) && $stable(rd_sel) &&
                               $stable(rd_sbprot) && $stable(rd_sbsel)));

   p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && erase_done) |=> (!busy && !rd_hv));

   p_hv_tracks_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hv == busy);

endmodule

bind erase_hv_gate ehg_chk #(
   .NUM_BLK(NUM_BLK),
   .NUM_SB (NUM_SB)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .ctl_wr          (ctl_wr),
   .wr_hv           (wr_hv),
   .erase_done      (erase_done),
   .busy            (busy),
   .hv_start        (hv_start),
   .seq_err         (seq_err),
   .rd_hv           (rd_hv),
   .rd_prot         (rd_prot),
   .rd_sel          (rd_sel),
   .rd_sbprot       (rd_sbprot),
   .rd_sbsel        (rd_sbsel),
   .erase_blk       (erase_blk),
   .erase_sb        (erase_sb),
   .prot_en_lat     (prot_en_lat),
   .blk0_prot_en_lat(blk0_prot_en_lat)
);

// File: tb/erase_hv_gate_tb_top.sv
module erase_hv_gate_tb_top;

   localparam int          NB   = 6;
   localparam int          NS   = 2;
   localparam int          AW   = 12;
   localparam int unsigned BASE = 32'h200;
   localparam int unsigned SIZE = 32'h180;

   logic          clk, rst_n;
   logic          ctl_wr, wr_pe, wr_ses, wr_hv, arr_wr, erase_done;
   logic [NB-1:0] wr_prot, wr_sel;
   logic [NS-1:0] wr_sbprot, wr_sbsel, sb_en;
   logic [AW-1:0] arr_addr;
   logic          prot_en_in, blk0_prot_en_in;
   logic [NB-1:0] rd_prot, rd_sel, erase_blk;
   logic [NS-1:0] rd_sbprot, rd_sbsel, erase_sb;
   logic          rd_pe, rd_ses, rd_hv, busy, seq_err, hv_start;
   logic          prot_en_lat, blk0_prot_en_lat;

   erase_hv_gate #(
      .NUM_BLK(NB), .NUM_SB(NS), .ADDR_W(AW), .ARR_BASE(BASE), .ARR_SIZE(SIZE)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr),
      .wr_prot(wr_prot), .wr_sbprot(wr_sbprot), .wr_sel(wr_sel), .wr_sbsel(wr_sbsel),
      .wr_pe(wr_pe), .wr_ses(wr_ses), .wr_hv(wr_hv),
      .arr_wr(arr_wr), .arr_addr(arr_addr), .sb_en(sb_en),
      .prot_en_in(prot_en_in), .blk0_prot_en_in(blk0_prot_en_in), .erase_done(erase_done),
      .rd_prot(rd_prot), .rd_sbprot(rd_sbprot), .rd_sel(rd_sel), .rd_sbsel(rd_sbsel),
      .rd_pe(rd_pe), .rd_ses(rd_ses), .rd_hv(rd_hv), .busy(busy), .seq_err(seq_err),
      .hv_start(hv_start), .erase_blk(erase_blk), .erase_sb(erase_sb),
      .prot_en_lat(prot_en_lat), .blk0_prot_en_lat(blk0_prot_en_lat)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   int n_vec = 0;
   int n_bad = 0;

   // reference model: 0 idle, 1 armed, 2 locked, 3 busy
   int            m_st;
   logic [NB-1:0] m_prot, m_sel, m_blk;
   logic [NS-1:0] m_sbprot, m_sbsel, m_sb;
   logic          m_pe, m_ses, m_hv, m_err, m_start, m_pl, m_b0l;

   function automatic logic [NB-1:0] exp_blk(logic [NB-1:0] sel, logic [NB-1:0] prot);
      return sel & ~prot;
   endfunction

   function automatic logic [NS-1:0] exp_sb(logic [NS-1:0] sel, logic [NS-1:0] prot,
                                            logic [NS-1:0] en);
      return sel & ~prot & en;
   endfunction

   function automatic bit in_win(logic [AW-1:0] a);
      return (32'(a) >= BASE) && (32'(a) < BASE + SIZE);
   endfunction

   task automatic cmp(string req, string what, logic [31:0] got, logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic check_all(string req);
      cmp(req, "rd_prot",   32'(rd_prot),   32'(m_prot));
      cmp(req, "rd_sbprot", 32'(rd_sbprot), 32'(m_sbprot));
      cmp(req, "rd_sel",    32'(rd_sel),    32'(m_sel));
      cmp(req, "rd_sbsel",  32'(rd_sbsel),  32'(m_sbsel));
      cmp(req, "rd_pe",     32'(rd_pe),     32'(m_pe));
      cmp(req, "rd_ses",    32'(rd_ses),    32'(m_ses));
      cmp(req, "rd_hv",     32'(rd_hv),     32'(m_hv));
      cmp(req, "busy",      32'(busy),      32'(m_st == 3));
      cmp(req, "seq_err",   32'(seq_err),   32'(m_err));
      cmp(req, "hv_start",  32'(hv_start),  32'(m_start));
      cmp(req, "erase_blk", 32'(erase_blk), 32'(m_blk));
      cmp(req, "erase_sb",  32'(erase_sb),  32'(m_sb));
      cmp(req, "prot_en_lat",      32'(prot_en_lat),      32'(m_pl));
      cmp(req, "blk0_prot_en_lat", 32'(blk0_prot_en_lat), 32'(m_b0l));
   endtask

   task automatic finish_op(string req);
      @(posedge clk);
      #1;
      ctl_wr = 1'b0; arr_wr = 1'b0; erase_done = 1'b0;
      check_all(req);
      @(negedge clk);
   endtask

   task automatic ctl_op(string req, logic [NB-1:0] prot, logic [NB-1:0] sel,
                         logic [NS-1:0] sbprot, logic [NS-1:0] sbsel,
                         logic pe, logic ses, logic hv);
      ctl_wr = 1'b1; wr_prot = prot; wr_sel = sel; wr_sbprot = sbprot; wr_sbsel = sbsel;
      wr_pe = pe; wr_ses = ses; wr_hv = hv;
      m_start = 1'b0;
      if (m_st != 3) begin
         m_prot = prot; m_sel = sel; m_sbprot = sbprot; m_sbsel = sbsel;
         m_pe = pe; m_ses = ses;
         if (!(pe && ses)) begin
            m_st = 0;
            if (hv) m_err = 1'b1;
         end else if (hv && m_st == 2) begin
            m_st = 3; m_start = 1'b1; m_hv = 1'b1; m_err = 1'b0;
            m_pl = prot_en_in; m_b0l = blk0_prot_en_in;
            m_blk = exp_blk(sel, prot);
            m_sb = exp_sb(sbsel, sbprot, sb_en);
         end else begin
            if (hv) m_err = 1'b1;
            if (m_st != 2) m_st = 1;
         end
      end
      finish_op(req);
   endtask

   task automatic arr_op(string req, logic [AW-1:0] a);
      arr_wr = 1'b1; arr_addr = a;
      m_start = 1'b0;
      if (m_st == 1 && in_win(a)) m_st = 2;
      finish_op(req);
   endtask

   task automatic done_op(string req);
      erase_done = 1'b1;
      m_start = 1'b0;
      if (m_st == 3) begin m_st = 0; m_hv = 1'b0; end
      finish_op(req);
   endtask

   task automatic idle_op(string req);
      m_start = 1'b0;
      finish_op(req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      rst_n = 1'b0; ctl_wr = 1'b0; arr_wr = 1'b0; erase_done = 1'b0;
      wr_prot = '0; wr_sel = '0; wr_sbprot = '0; wr_sbsel = '0;
      wr_pe = 1'b0; wr_ses = 1'b0; wr_hv = 1'b0; arr_addr = '0;
      sb_en = 2'b11; prot_en_in = 1'b0; blk0_prot_en_in = 1'b0;
      m_st = 0; m_prot = '1; m_sbprot = '1; m_sel = '0; m_sbsel = '0;
      m_pe = 0; m_ses = 0; m_hv = 0; m_err = 0; m_start = 0;
      m_blk = '0; m_sb = '0; m_pl = 0; m_b0l = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // R2: plain field load, not armed
      ctl_op("R2", 6'b000011, 6'b101101, 2'b01, 2'b11, 1'b0, 1'b0, 1'b0);
      // R3: arm, miss the window on both sides, request is rejected
      ctl_op("R3", 6'b000011, 6'b101101, 2'b01, 2'b11, 1'b1, 1'b1, 1'b0);
      arr_op("R3", 12'h1FF);
      arr_op("R3", 12'h380);
      ctl_op("R3", 6'b000011, 6'b101101, 2'b01, 2'b11, 1'b1, 1'b1, 1'b1);
      // R4 / R8 / R7: interlock at last window address, then grant
      arr_op("R3", 12'h37F);
      prot_en_in = 1'b1; blk0_prot_en_in = 1'b0; sb_en = 2'b10;
      ctl_op("R4", 6'b000011, 6'b101101, 2'b01, 2'b11, 1'b1, 1'b1, 1'b1);
      prot_en_in = 1'b0; blk0_prot_en_in = 1'b1; sb_en = 2'b11;
      idle_op("R7");
      // R9: writes while busy are dropped
      ctl_op("R9", 6'b111100, 6'b010010, 2'b10, 2'b00, 1'b0, 1'b1, 1'b1);
      // R10: done clears busy; stray done has no effect
      done_op("R10");
      done_op("R10");
      // R6: arm, interlock at first window address, then drop program-enable
      ctl_op("R6", 6'b000000, 6'b111111, 2'b00, 2'b11, 1'b1, 1'b1, 1'b0);
      arr_op("R6", 12'h200);
      ctl_op("R6", 6'b000000, 6'b111111, 2'b00, 2'b11, 1'b0, 1'b1, 1'b0);
      ctl_op("R6", 6'b000000, 6'b111111, 2'b00, 2'b11, 1'b1, 1'b1, 1'b1);
      // R5: request straight after arming; array write while idle is ignored
      ctl_op("R5", 6'b000000, 6'b000000, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0);
      arr_op("R5", 12'h250);
      ctl_op("R5", 6'b010101, 6'b111111, 2'b11, 2'b01, 1'b1, 1'b1, 1'b1);
      // R8: fully protected selection gives an empty mask
      arr_op("R8", 12'h2C0);
      ctl_op("R8", 6'b111111, 6'b111111, 2'b11, 2'b11, 1'b1, 1'b1, 1'b1);
      done_op("R8");

      // constrained random mix
      for (int k = 0; k < 1500; k++) begin
         int r;
         r = int'($urandom % 10);
         prot_en_in = 1'($urandom); blk0_prot_en_in = 1'($urandom);
         sb_en = NS'($urandom);
         if (r < 4) begin
            ctl_op("R2", NB'($urandom), NB'($urandom), NS'($urandom), NS'($urandom),
                   ($urandom % 5) != 0, ($urandom % 5) != 0, ($urandom % 3) == 0);
         end else if (r < 7) begin
            arr_op("R3", AW'(32'h1C0 + ($urandom % 32'h200)));
         end else if (r == 7) begin
            done_op("R10");
         end else begin
            idle_op("R9");
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule